// File: doc/BRIEF.md
# Configurable External Interrupt Edge Detector

This block watches sixteen general-purpose port inputs and eight dedicated interrupt request inputs, and keeps one pending flag for each line. How a line raises its flag is set by one mode bit per line, held in a 32-bit control word whose bits are numbered big-endian: bit 0 of the word is data bit 31. A port line either reacts to any transition or only to a falling edge. A request line is either level sensitive, which means a low level requests service, or it reacts only to a falling edge.

Every input first passes through a two-flop synchroniser. An edge is found by comparing the synchronised level with its value one clock earlier. A small register bus is used to program the modes, read the pending flags and clear them by writing 1, and set a per-line mask. The single active-high interrupt output is the OR of the pending flags that the mask lets through.

Top module: `xirq_edge_ctl`

## Requirements
- R1: Register 0 holds the mode word. Big-endian word bit i is data bit 31-i. Port line k uses data bit 31-k, and request line j uses data bit 15-j. The written value reads back unchanged in those 24 positions.
- R2: When a port line's mode bit is 0, every rising or falling transition sets pending bit k of register 1. The flag can be read after the third rising clock edge that follows the input change.
- R3: When a port line's mode bit is 1, a rising transition leaves its pending bit unchanged, and a falling transition sets it with the same latency as in R2.
- R4: When a request line's mode bit is 0, pending bit 16+j of register 1 equals the inverse of the synchronised line level, three edges after the input. Writing 1 to clear it has no effect while the line stays low.
- R5: When a request line's mode bit is 1, a falling transition sets pending bit 16+j, which then stays set when the line rises again until it is cleared.
- R6: Data bits 7:0 of register 0 always read as zero, and writes to them are ignored.
- R7: After the synchronous reset, the mode word, pending flags, mask and irq output are all zero. The synchronisers of the request lines reset to high, and those of the port lines reset to low.
- R8: Writing register 1 clears each edge-mode pending bit whose data bit is 1. Bits written as 0 are unchanged. A new event on the same clock edge wins over the clear.
- R9: A new mode takes effect from the clock edge that writes it. The change by itself never sets a pending bit.
- R10: Register 2 bits 23:0 are the mask, using the same line order as register 1. irq is high in the same cycle that any pending bit with its mask bit set is 1, with no register delay. Register 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | 16 | Asynchronous general-purpose port lines |
| req_in | input | 8 | Asynchronous interrupt request lines |
| bus_addr | input | 2 | Register select: 0 mode, 1 pending, 2 mask, 3 none |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | OR of the pending flags that pass the mask |

## Verification
An input change reaches a pending flag after three rising edges: two synchroniser stages, then the pending register, which is loaded while the previous-level flop still holds the old value. Bus writes land at the edge they are sampled on. Reads and irq are combinational, so a result is visible just after the edge that updates the state. The reference model keeps a history of input samples, one per edge, and takes the sample from two edges back as the synchronised level and the one from three edges back as its previous value. It compares read data and irq shortly after each rising edge, while the inputs are only changed on falling edges. The directed steps wait at least four cycles before each named check of a pending value.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    parameter int unsigned XQ_DATA_W = 32;
    parameter int unsigned XQ_N_PORT = 16;
    parameter int unsigned XQ_N_REQ  = 8;
    localparam int unsigned XQ_N_LINE = XQ_N_PORT + XQ_N_REQ;

    typedef enum logic [1:0] {
        XQ_REG_MODE = 2'd0,
        XQ_REG_PEND = 2'd1,
        XQ_REG_MASK = 2'd2,
        XQ_REG_NONE = 2'd3
    } xq_reg_e;

    typedef enum logic {
        XQ_KIND_PORT = 1'b0,
        XQ_KIND_REQ  = 1'b1
    } xq_kind_e;

    typedef struct packed {
        logic lvl;
        logic prev;
    } xq_samp_s;

    // Edge-event decode for one line; a level-mode request line produces no edge event.
    function automatic logic xq_edge_event(xq_kind_e kind, logic mode, xq_samp_s s);
        logic fall;
        logic chg;
        fall = s.prev & ~s.lvl;
        chg  = s.prev ^ s.lvl;
        if (kind == XQ_KIND_PORT) begin
            return mode ? fall : chg;
        end
        return mode ? fall : 1'b0;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
#(
    parameter xq_kind_e KIND = XQ_KIND_PORT,
    parameter logic RST_BIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic mode,
    input  logic clr,
    output logic pend
);
    logic     prev_q;
    logic     pend_q;
    logic     pend_d;
    logic     evt;
    xq_samp_s samp;

    assign samp.lvl  = lvl;
    assign samp.prev = prev_q;
    assign evt       = xq_edge_event(KIND, mode, samp);

    always_comb begin
        if (KIND == XQ_KIND_REQ && !mode) begin
            pend_d = ~lvl;
        end else begin
            pend_d = evt | (pend_q & ~clr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= RST_BIT;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

    generate
        if (KIND == XQ_KIND_PORT) begin : g_port_chk
            p_any_change_r2: assert property (@(posedge clk) disable iff (rst)
                (!mode && (lvl != prev_q)) |=> pend_q);
            p_fall_only_r3: assert property (@(posedge clk) disable iff (rst)
                (mode && !(prev_q && !lvl) && !pend_q) |=> !pend_q);
            p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
                (pend_q && clr && (lvl == prev_q)) |=> !pend_q);
        end else begin : g_req_chk
            p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
                !mode |=> (pend_q == !$past(lvl)));
            p_edge_sticky_r5: assert property (@(posedge clk) disable iff (rst)
                (mode && pend_q && !clr) |=> pend_q);
        end
    endgenerate
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int unsigned DATA_W = XQ_DATA_W,
    parameter int unsigned N_LINE = XQ_N_LINE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N_LINE-1:0] pend,
    output logic [N_LINE-1:0] mode,
    output logic [N_LINE-1:0] mask,
    output logic [N_LINE-1:0] clr,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned RSVD_W = DATA_W - N_LINE;

    xq_reg_e           sel;
    logic [N_LINE-1:0] mode_q;
    logic [N_LINE-1:0] mask_q;
    logic [N_LINE-1:0] mode_wr;
    logic [DATA_W-1:0] mode_word;
    logic              unused_wdata_low;

    assign sel              = xq_reg_e'(bus_addr);
    assign unused_wdata_low = ^bus_wdata[RSVD_W-1:0];

    // Big-endian numbering: word bit i lives at data bit DATA_W-1-i.
    always_comb begin
        mode_word = '0;
        for (int i = 0; i < int'(N_LINE); i++) begin
            mode_word[DATA_W-1-i] = mode_q[i];
            mode_wr[i]            = bus_wdata[DATA_W-1-i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (sel == XQ_REG_MODE) mode_q <= mode_wr;
            if (sel == XQ_REG_MASK) mask_q <= bus_wdata[N_LINE-1:0];
        end
    end

    assign clr  = (bus_wr && sel == XQ_REG_PEND) ? bus_wdata[N_LINE-1:0] : '0;
    assign mode = mode_q;
    assign mask = mask_q;

    always_comb begin
        unique case (sel)
            XQ_REG_MODE: bus_rdata = mode_word;
            XQ_REG_PEND: bus_rdata = {{RSVD_W{1'b0}}, pend};
            XQ_REG_MASK: bus_rdata = {{RSVD_W{1'b0}}, mask_q};
            default:     bus_rdata = '0;
        endcase
    end

    p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (sel == XQ_REG_MODE) |-> (bus_rdata[RSVD_W-1:0] == '0));
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel == XQ_REG_MODE) |=> $stable(mode_q));
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel == XQ_REG_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/xirq_edge_ctl.sv
module xirq_edge_ctl
    import xirq_pkg::*;
#(
    parameter int unsigned N_PORT = XQ_N_PORT,
    parameter int unsigned N_REQ  = XQ_N_REQ,
    parameter int unsigned DATA_W = XQ_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PORT-1:0] port_in,
    input  logic [N_REQ-1:0]  req_in,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned N_LINE = N_PORT + N_REQ;
    localparam logic [N_LINE-1:0] SYNC_RST = {{N_REQ{1'b1}}, {N_PORT{1'b0}}};

    logic [N_LINE-1:0] raw;
    logic [N_LINE-1:0] lvl;
    logic [N_LINE-1:0] mode;
    logic [N_LINE-1:0] mask;
    logic [N_LINE-1:0] clr;
    logic [N_LINE-1:0] pend;

    assign raw = {req_in, port_in};

    xirq_sync #(
        .W       (N_LINE),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .dout (lvl)
    );

    generate
        for (genvar i = 0; i < int'(N_LINE); i++) begin : g_line
            xirq_line #(
                .KIND    ((i < int'(N_PORT)) ? XQ_KIND_PORT : XQ_KIND_REQ),
                .RST_BIT (SYNC_RST[i])
            ) u_line (
                .clk  (clk),
                .rst  (rst),
                .lvl  (lvl[i]),
                .mode (mode[i]),
                .clr  (clr[i]),
                .pend (pend[i])
            );
        end
    endgenerate

    xirq_regs #(
        .DATA_W (DATA_W),
        .N_LINE (N_LINE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pend      (pend),
        .mode      (mode),
        .mask      (mask),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    assign irq = |(pend & mask);
endmodule

// File: tb/xirq_edge_ctl_bench.sv
module xirq_edge_ctl_bench;
    localparam int PERIOD = 10;
    localparam logic [23:0] SYNC_RST = 24'hFF0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] port_in = '0;
    logic [7:0]  req_in = 8'hFF;
    logic [1:0]  bus_addr = 2'd1;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    xirq_edge_ctl u_xirq_edge_ctl (
        .clk(clk), .rst(rst), .port_in(port_in), .req_in(req_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference model
    logic [23:0] m_mode = '0, m_mask = '0, m_pend = '0;
    logic [23:0] hist[$];

    function automatic logic [23:0] hget(int k);
        if (hist.size() > k) return hist[k];
        return SYNC_RST;
    endfunction

    function automatic logic [31:0] model_read(logic [1:0] a);
        logic [31:0] w;
        w = '0;
        case (a)
            2'd0: for (int i = 0; i < 24; i++) w[31-i] = m_mode[i];
            2'd1: w = {8'h00, m_pend};
            2'd2: w = {8'h00, m_mask};
            default: w = '0;
        endcase
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = '0; m_mask = '0; m_pend = '0;
            hist.push_front(SYNC_RST);
        end else begin
            logic [23:0] now, pv, np;
            hist.push_front({req_in, port_in});
            now = hget(2);
            pv  = hget(3);
            for (int i = 0; i < 24; i++) begin
                logic clr_i, ev;
                clr_i = bus_wr && bus_addr == 2'd1 && bus_wdata[i];
                if (i < 16) begin
                    ev = m_mode[i] ? (pv[i] && !now[i]) : (pv[i] != now[i]);
                    np[i] = ev || (m_pend[i] && !clr_i);
                end else if (m_mode[i]) begin
                    np[i] = (pv[i] && !now[i]) || (m_pend[i] && !clr_i);
                end else begin
                    np[i] = !now[i];
                end
            end
            m_pend = np;
            if (bus_wr && bus_addr == 2'd0)
                for (int i = 0; i < 24; i++) m_mode[i] = bus_wdata[31-i];
            if (bus_wr && bus_addr == 2'd2) m_mask = bus_wdata[23:0];
        end
        while (hist.size() > 6) void'(hist.pop_back());
    end

    function automatic string tag_of(logic [1:0] a);
        case (a)
            2'd0: return "R1 R6 R9";
            2'd1: return "R2 R3 R4 R5 R8";
            default: return "R10";
        endcase
    endfunction

    // Per-cycle comparison just after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            logic [31:0] er;
            logic ei;
            er = model_read(bus_addr);
            ei = |(m_pend & m_mask);
            checks++;
            if (bus_rdata !== er) begin
                fails++;
                $display("FAIL %s addr=%0d rdata actual=%h expected=%h", tag_of(bus_addr), bus_addr, bus_rdata, er);
            end
            checks++;
            if (irq !== ei) begin
                fails++;
                $display("FAIL R10 irq actual=%b expected=%b", irq, ei);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd1;
    endtask

    task automatic expect_rd(logic [1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk); #2;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
        @(negedge clk);
        bus_addr = 2'd1;
    endtask

    task automatic expect_irq(logic exp, string tag);
        @(posedge clk); #2;
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        wait_cyc(5);
        rst = 1'b0;
        // R7 reset state
        expect_rd(2'd0, 32'h0, "R7");
        expect_rd(2'd1, 32'h0, "R7");
        expect_rd(2'd2, 32'h0, "R7");
        expect_irq(1'b0, "R7");
        expect_rd(2'd3, 32'h0, "R10");

        bus_write(2'd2, 32'h00FF_FFFF);
        // R2 any change on port 3
        @(negedge clk); port_in[3] = 1'b1;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0000_0008, "R2");
        bus_write(2'd1, 32'h0000_0008);
        expect_rd(2'd1, 32'h0, "R8");
        @(negedge clk); port_in[3] = 1'b0;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0000_0008, "R2");
        bus_write(2'd1, 32'h0000_0008);

        // R3 falling only on port 5
        bus_write(2'd0, 32'h0400_0000);
        @(negedge clk); port_in[5] = 1'b1;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0, "R3");
        @(negedge clk); port_in[5] = 1'b0;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0000_0020, "R3");
        bus_write(2'd1, 32'h0000_0020);

        // R4 level-low on request 2
        @(negedge clk); req_in[2] = 1'b0;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0004_0000, "R4");
        bus_write(2'd1, 32'h0004_0000);
        wait_cyc(2);
        expect_rd(2'd1, 32'h0004_0000, "R4");
        expect_irq(1'b1, "R4");
        @(negedge clk); req_in[2] = 1'b1;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0, "R4");

        // R5 falling edge on request 4, R1 readback
        bus_write(2'd0, 32'h0400_0800);
        expect_rd(2'd0, 32'h0400_0800, "R1");
        @(negedge clk); req_in[4] = 1'b0;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0010_0000, "R5");
        @(negedge clk); req_in[4] = 1'b1;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0010_0000, "R5");
        bus_write(2'd1, 32'h0010_0000);
        expect_rd(2'd1, 32'h0, "R8");

        // R9 mode change alone creates no event
        @(negedge clk); port_in[7] = 1'b1;
        wait_cyc(4);
        bus_write(2'd1, 32'h0000_0080);
        bus_write(2'd0, 32'h0500_0800);
        wait_cyc(4);
        expect_rd(2'd1, 32'h0, "R9");
        @(negedge clk); port_in[7] = 1'b0;
        wait_cyc(4);
        expect_rd(2'd1, 32'h0000_0080, "R9");

        // R10 mask gating, same-cycle irq
        bus_write(2'd2, 32'h0);
        expect_irq(1'b0, "R10");
        @(negedge clk); bus_addr = 2'd2; bus_wdata = 32'h0000_0080; bus_wr = 1'b1;
        expect_irq(1'b1, "R10");
        @(negedge clk); bus_wr = 1'b0; bus_addr = 2'd1;
        bus_write(2'd1, 32'h0000_0080);

        // R6 reserved bits
        bus_write(2'd0, 32'hFFFF_FFFF);
        expect_rd(2'd0, 32'hFFFF_FF00, "R6");
        bus_write(2'd0, 32'h0);

        // Mixed pattern, compared every cycle against the model
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            port_in = port_in ^ (lfsr[15:0] & lfsr[31:16]);
            if (lfsr[3:0] == 4'h5) req_in = lfsr[27:20];
            bus_wr = 1'b0;
            bus_addr = lfsr[9:8];
            if (lfsr[6:4] == 3'd0) begin
                bus_wr = 1'b1; bus_wdata = {lfsr[15:0], lfsr[31:16]};
            end
        end
        @(negedge clk); bus_wr = 1'b0; bus_addr = 2'd1;
        wait_cyc(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule